// File: doc/BRIEF.md
# DDR2 Rank Window Decoder with Controller Enable

This block is the address-decode front end of a DDR2-style memory controller. It holds up to four rank configuration words, each packing a base address, a size code and a valid flag, and turns a 34-bit physical address into a rank hit, the index of the rank that was hit, and the offset of the address inside that rank. The size code is a 10-bit count `f`, and the rank spans (1024 − f) × 8 MiB. The base is kept in the word shifted right by two bits, so ranks can be placed anywhere in a 16 GiB space.

The rank words are fixed at build time by a parameter. Software reads them back through directly numbered register ports, and writes to those ports are dropped. Other control goes through an index/data port pair. Software writes an index to the index port, then reads or writes the data port. Behind the data port sit the controller-options register, which holds the enable bit, and a few locations that return constant status values. Decoding is gated by a small control state machine. In state CTL_OFF no address hits any rank. In state CTL_ON the rank windows are live. Transition TURN_ON happens on an options write with the enable bit set while in CTL_OFF. Transition TURN_OFF happens on an options write with the enable bit clear while in CTL_ON. Any other options write leaves the state as it is.

The decoder registers its result: an address presented before a clock edge produces its hit, rank and offset after that edge. The decode uses the enable state that held before that edge. A register read is also registered: read data is captured on the edge where the read strobe is high, and it is held until the next read.

Top module: `ddr2rd_top`

## Requirements
- R1: After reset the index register is 0, the options register is 0, the control state is CTL_OFF (no address hits), `reg_rdata` is 0 and `dec_hit` is 0.
- R2: Each rank word is stored as the parameter word ANDed with 0xFFE0FFC1. Rank i reads back, so masked, at direct port number 0x40 + i.
- R3: A write to any direct rank port (0x40 to 0x43) has no effect on the value read back from it.
- R4: A write to port 0x10 stores the full 32-bit index, and a read of port 0x10 returns it.
- R5: Writing the data port (0x11) while the index is 0x21 updates the options register. Only bit 27, the enable, is kept, so a data-port read at index 0x21 returns 0x08000000 when enabled and 0 otherwise. Setting bit 27 enters CTL_ON and clearing it returns to CTL_OFF.
- R6: Data-port reads return 0x80000000 at index 0x14 and at index 0x1F, 0x00008001 at index 0x40, 0x02000000 at index 0x7A, and 0 at every other index except 0x21. Data-port writes at any index other than 0x21 change nothing.
- R7: The base of a rank is word bits 31:21 placed at address bits 33:23, with all lower address bits 0.
- R8: The size of a rank is (1024 − f) × 8 MiB, where f is word bits 15:6. So 0xFFC0 means 8 MiB and 0x8000 means 4 GiB.
- R9: An address hits rank i only when word bit 0 is 1, the state is CTL_ON, and base ≤ address < base + size. On a hit `dec_offset` is address − base and `dec_rank` is i. On a miss both are 0.
- R10: The decode result appears after the clock edge that follows the address. Addresses decoded while in CTL_OFF never hit.
- R11: `reg_rdata` is loaded on each edge where `reg_rd` is 1 and holds otherwise. A read of a port number that is not 0x10, 0x11 or a rank port returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 10 | Register port number for a read or write |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| mem_addr | input | 34 | Physical address to decode |
| dec_hit | output | 1 | Address lies in an enabled valid rank |
| dec_rank | output | 2 | Index of the rank that was hit |
| dec_offset | output | 34 | Offset of the address within the rank |

## Verification
On every cycle the assertions check four things. The control state only enters or leaves CTL_ON in the cycle after an options write that asks for it. No hit appears for an address decoded while disabled. A miss always reports a zero rank and a zero offset. Read data never changes without a read strobe. Other behaviour needs the bench's directed scenarios: the exact masked values of the rank words, the fixed status constants behind the index/data pair, the window edges at base and base + size (including ranks above 4 GiB and an invalid rank whose window would otherwise match), and that writes to rank ports or to other indices leave the state unchanged.

// File: rtl/ddr2rd_pkg.sv
package ddr2rd_pkg;

    // Physical address width and geometry of a rank word
    localparam int ADDR_W      = 34;
    localparam int WORD_W      = 32;
    localparam int BASE_LO     = 21;             // word bit holding the lowest base bit
    localparam int BASE_SHIFT  = 2;              // stored base is address >> 2
    localparam int GRAIN_LOG2  = 23;             // 8 MiB granule
    localparam int FIELD_LO    = 6;
    localparam int FIELD_W     = 10;
    localparam int SPAN_W      = FIELD_W + 1;    // holds 1024 - f
    localparam int LIMIT_W     = ADDR_W + 1;     // base + size can exceed 2^34

    localparam logic [WORD_W-1:0] RANK_MASK = 32'hFFE0_FFC1;

    // Indirect locations behind the data port
    localparam logic [WORD_W-1:0] IDX_READY_A = 32'h0000_0014;
    localparam logic [WORD_W-1:0] IDX_READY_B = 32'h0000_001F;
    localparam logic [WORD_W-1:0] IDX_OPTIONS = 32'h0000_0021;
    localparam logic [WORD_W-1:0] IDX_BANKCFG = 32'h0000_0040;
    localparam logic [WORD_W-1:0] IDX_DLLCFG  = 32'h0000_007A;

    localparam logic [WORD_W-1:0] VAL_READY   = 32'h8000_0000;
    localparam logic [WORD_W-1:0] VAL_BANKCFG = 32'h0000_8001;
    localparam logic [WORD_W-1:0] VAL_DLLCFG  = 32'h0200_0000;

    localparam int EN_BIT = 27;

    typedef enum logic {
        CTL_OFF = 1'b0,
        CTL_ON  = 1'b1
    } ctl_state_t;

    typedef struct packed {
        logic               valid;
        logic [ADDR_W-1:0]  base;
        logic [LIMIT_W-1:0] limit;
    } rank_win_t;

endpackage

// File: rtl/ddr2rd_rank_table.sv
module ddr2rd_rank_table
    import ddr2rd_pkg::*;
#(
    parameter int                          NUM_RANKS  = 4,
    parameter logic [NUM_RANKS*WORD_W-1:0] RANK_WORDS = '0
) (
    output logic [NUM_RANKS-1:0][WORD_W-1:0] rank_words,
    output rank_win_t [NUM_RANKS-1:0]        rank_wins
);

    localparam int BASE_BITS = WORD_W - BASE_LO;   // 11 stored base bits
    localparam int LOW_ZERO  = ADDR_W - BASE_BITS; // address bits below the base field

    for (genvar g = 0; g < NUM_RANKS; g++) begin : g_rank
        logic [WORD_W-1:0]  word;
        logic [FIELD_W-1:0] field;
        logic [SPAN_W-1:0]  span;
        logic [ADDR_W-1:0]  size;

        assign word  = RANK_WORDS[g*WORD_W +: WORD_W] & RANK_MASK;
        assign field = word[FIELD_LO +: FIELD_W];
        assign span  = SPAN_W'(1 << FIELD_W) - {1'b0, field};
        assign size  = {span, {GRAIN_LOG2{1'b0}}};

        assign rank_words[g]      = word;
        assign rank_wins[g].valid = word[0];
        assign rank_wins[g].base  = {word[WORD_W-1:BASE_LO], {LOW_ZERO{1'b0}}};
        assign rank_wins[g].limit = {1'b0, rank_wins[g].base} + {1'b0, size};
    end

endmodule

// File: rtl/ddr2rd_ctl.sv
module ddr2rd_ctl
    import ddr2rd_pkg::*;
#(
    parameter int NUM_RANKS  = 4,
    parameter int SEL_W      = 10,
    parameter int PORT_INDEX = 'h10,
    parameter int PORT_DATA  = 'h11,
    parameter int PORT_RANK0 = 'h40
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [SEL_W-1:0]                 reg_sel,
    input  logic                             reg_wr,
    input  logic                             reg_rd,
    input  logic [WORD_W-1:0]                reg_wdata,
    input  logic [NUM_RANKS-1:0][WORD_W-1:0] rank_words,
    output logic [WORD_W-1:0]                reg_rdata,
    output logic                             ctl_en
);

    localparam logic [SEL_W-1:0] SEL_INDEX = SEL_W'(PORT_INDEX);
    localparam logic [SEL_W-1:0] SEL_DATA  = SEL_W'(PORT_DATA);

    ctl_state_t        state_q, state_d;
    logic [WORD_W-1:0] index_q;
    logic [WORD_W-1:0] opt_value;
    logic [WORD_W-1:0] rd_value;
    logic [WORD_W-1:0] ind_value;
    logic              opt_wr;

    assign opt_wr = reg_wr && (reg_sel == SEL_DATA) && (index_q == IDX_OPTIONS);

    // Index register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
        end else if (reg_wr && reg_sel == SEL_INDEX) begin
            index_q <= reg_wdata;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTL_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: TURN_ON / TURN_OFF
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_OFF: if (opt_wr && reg_wdata[EN_BIT])  state_d = CTL_ON;
            CTL_ON:  if (opt_wr && !reg_wdata[EN_BIT]) state_d = CTL_OFF;
            default: state_d = CTL_OFF;
        endcase
    end

    // State outputs
    always_comb begin
        ctl_en    = 1'b0;
        opt_value = '0;
        unique case (state_q)
            CTL_OFF: begin
                ctl_en    = 1'b0;
                opt_value = '0;
            end
            CTL_ON: begin
                ctl_en    = 1'b1;
                opt_value = WORD_W'(1) << EN_BIT;
            end
            default: begin
                ctl_en    = 1'b0;
                opt_value = '0;
            end
        endcase
    end

    // Indirect read values
    always_comb begin
        unique case (index_q)
            IDX_READY_A, IDX_READY_B: ind_value = VAL_READY;
            IDX_OPTIONS:              ind_value = opt_value;
            IDX_BANKCFG:              ind_value = VAL_BANKCFG;
            IDX_DLLCFG:               ind_value = VAL_DLLCFG;
            default:                  ind_value = '0;
        endcase
    end

    // Port read mux
    always_comb begin
        rd_value = '0;
        if (reg_sel == SEL_INDEX) begin
            rd_value = index_q;
        end else if (reg_sel == SEL_DATA) begin
            rd_value = ind_value;
        end else begin
            for (int i = 0; i < NUM_RANKS; i++) begin
                if (reg_sel == SEL_W'(PORT_RANK0 + i)) begin
                    rd_value = rank_words[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_value;
        end
    end

    AST_EN_RISE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_en) |-> $past(opt_wr && reg_wdata[EN_BIT])); // R5

    AST_EN_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_en) |-> $past(opt_wr && !reg_wdata[EN_BIT])); // R5

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata)); // R11

endmodule

// File: rtl/ddr2rd_match.sv
module ddr2rd_match
    import ddr2rd_pkg::*;
#(
    parameter int NUM_RANKS  = 4,
    parameter int RANK_IDX_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctl_en,
    input  rank_win_t [NUM_RANKS-1:0] rank_wins,
    input  logic [ADDR_W-1:0]         mem_addr,
    output logic                      dec_hit,
    output logic [RANK_IDX_W-1:0]     dec_rank,
    output logic [ADDR_W-1:0]         dec_offset
);

    logic [NUM_RANKS-1:0]  raw_hit;
    logic                  hit_c;
    logic [RANK_IDX_W-1:0] rank_c;
    logic [ADDR_W-1:0]     off_c;

    for (genvar g = 0; g < NUM_RANKS; g++) begin : g_cmp
        logic above_base;
        logic below_limit;
        assign above_base  = mem_addr >= rank_wins[g].base;
        assign below_limit = {1'b0, mem_addr} < rank_wins[g].limit;
        assign raw_hit[g]  = ctl_en && rank_wins[g].valid && above_base && below_limit;
    end

    // Lowest-numbered rank wins when windows overlap
    always_comb begin
        hit_c  = 1'b0;
        rank_c = '0;
        off_c  = '0;
        for (int i = NUM_RANKS - 1; i >= 0; i--) begin
            if (raw_hit[i]) begin
                hit_c  = 1'b1;
                rank_c = RANK_IDX_W'(i);
                off_c  = mem_addr - rank_wins[i].base;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_hit    <= 1'b0;
            dec_rank   <= '0;
            dec_offset <= '0;
        end else begin
            dec_hit    <= hit_c;
            dec_rank   <= rank_c;
            dec_offset <= off_c;
        end
    end

    AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> !dec_hit); // R10

    AST_MISS_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_hit |-> (dec_rank == '0 && dec_offset == '0)); // R9

endmodule

// File: rtl/ddr2rd_top.sv
module ddr2rd_top
    import ddr2rd_pkg::*;
#(
    parameter int                          NUM_RANKS  = 4,
    parameter int                          SEL_W      = 10,
    parameter int                          PORT_INDEX = 'h10,
    parameter int                          PORT_DATA  = 'h11,
    parameter int                          PORT_RANK0 = 'h40,
    parameter logic [NUM_RANKS*WORD_W-1:0] RANK_WORDS = {
        32'h801F_803F, 32'h401F_FFFE, 32'h0400_FC01, 32'h0000_F801
    },
    localparam int RANK_IDX_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SEL_W-1:0]      reg_sel,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [WORD_W-1:0]     reg_wdata,
    output logic [WORD_W-1:0]     reg_rdata,
    input  logic [ADDR_W-1:0]     mem_addr,
    output logic                  dec_hit,
    output logic [RANK_IDX_W-1:0] dec_rank,
    output logic [ADDR_W-1:0]     dec_offset
);

    logic [NUM_RANKS-1:0][WORD_W-1:0] rank_words;
    rank_win_t [NUM_RANKS-1:0]        rank_wins;
    logic                             ctl_en;

    ddr2rd_rank_table #(
        .NUM_RANKS  (NUM_RANKS),
        .RANK_WORDS (RANK_WORDS)
    ) u_table (
        .rank_words (rank_words),
        .rank_wins  (rank_wins)
    );

    ddr2rd_ctl #(
        .NUM_RANKS  (NUM_RANKS),
        .SEL_W      (SEL_W),
        .PORT_INDEX (PORT_INDEX),
        .PORT_DATA  (PORT_DATA),
        .PORT_RANK0 (PORT_RANK0)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_sel    (reg_sel),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .rank_words (rank_words),
        .reg_rdata  (reg_rdata),
        .ctl_en     (ctl_en)
    );

    ddr2rd_match #(
        .NUM_RANKS  (NUM_RANKS),
        .RANK_IDX_W (RANK_IDX_W)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_en     (ctl_en),
        .rank_wins  (rank_wins),
        .mem_addr   (mem_addr),
        .dec_hit    (dec_hit),
        .dec_rank   (dec_rank),
        .dec_offset (dec_offset)
    );

endmodule

// File: tb/ddr2rd_top_bench.sv
`timescale 1ns/1ps
module ddr2rd_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [33:0] mem_addr = '0;
    logic        dec_hit;
    logic [1:0]  dec_rank;
    logic [33:0] dec_offset;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Raw words given to the design (same as its defaults)
    logic [31:0] raw_words [4] = '{32'h0000_F801, 32'h0400_FC01, 32'h401F_FFFE, 32'h801F_803F};

    always #2 clk = ~clk;

    ddr2rd_top u_ddr2rd_top (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
        .dec_hit(dec_hit), .dec_rank(dec_rank), .dec_offset(dec_offset)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [9:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [9:0] sel, output logic [31:0] data);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        data = reg_rdata;
    endtask

    function automatic logic [31:0] masked(input int i);
        return raw_words[i] & 32'hFFE0_FFC1;
    endfunction

    // Model of R7..R9
    task automatic dec_check(input string req, input logic [33:0] a, input bit en);
        longint base, size;
        bit      eh = 0;
        int      er = 0;
        longint  eo = 0;
        logic [31:0] w;
        for (int i = 3; i >= 0; i--) begin
            w    = masked(i);
            base = longint'(w >> 21) * 64'd8388608;
            size = (64'd1024 - longint'((w >> 6) & 32'h3FF)) * 64'd8388608;
            if (en && w[0] && longint'(a) >= base && longint'(a) < base + size) begin
                eh = 1; er = i; eo = longint'(a) - base;
            end
        end
        @(negedge clk);
        mem_addr = a;
        @(negedge clk);
        chk({req, " hit"}, 64'(dec_hit), 64'(eh));
        chk({req, " rank"}, 64'(dec_rank), 64'(er));
        chk({req, " offset"}, 64'(dec_offset), 64'(eo));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 rdata after reset", 64'(reg_rdata), 0);
        chk("R1 dec_hit after reset", 64'(dec_hit), 0);
        do_read(10'h010, d);
        chk("R1 index reset", 64'(d), 0);
        do_write(10'h010, 32'h21);
        do_read(10'h011, d);
        chk("R1 options reset", 64'(d), 0);
        dec_check("R1 disabled at reset", 34'h0, 0);
    endtask

    task automatic t_rank_readback;
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            do_read(10'(10'h040 + i), d);
            chk("R2 rank readback", 64'(d), 64'(masked(i)));
        end
    endtask

    task automatic t_rank_write_ignored;
        logic [31:0] d;
        do_write(10'h041, 32'hDEAD_BEEF);
        do_write(10'h043, 32'h0000_0000);
        do_read(10'h041, d);
        chk("R3 rank1 after write", 64'(d), 64'(masked(1)));
        do_read(10'h043, d);
        chk("R3 rank3 after write", 64'(d), 64'(masked(3)));
    endtask

    task automatic t_index_port;
        logic [31:0] d;
        do_write(10'h010, 32'hA5C3_0F7E);
        do_read(10'h010, d);
        chk("R4 index readback", 64'(d), 64'h0A5C3_0F7E);
    endtask

    task automatic t_fixed_reads;
        logic [31:0] d;
        logic [31:0] idx [5] = '{32'h14, 32'h1F, 32'h40, 32'h7A, 32'h33};
        logic [31:0] exp [5] = '{32'h8000_0000, 32'h8000_0000, 32'h0000_8001, 32'h0200_0000, 32'h0};
        for (int i = 0; i < 5; i++) begin
            do_write(10'h010, idx[i]);
            do_read(10'h011, d);
            chk("R6 fixed read", 64'(d), 64'(exp[i]));
        end
        do_write(10'h010, 32'h14);
        do_write(10'h011, 32'hFFFF_FFFF);
        do_write(10'h010, 32'h21);
        do_read(10'h011, d);
        chk("R6 write at other index ignored", 64'(d), 0);
        dec_check("R6 still disabled", 34'h100, 0);
    endtask

    task automatic t_options_enable;
        logic [31:0] d;
        do_write(10'h010, 32'h21);
        do_write(10'h011, 32'hFFFF_FFFF);
        do_read(10'h011, d);
        chk("R5 options only enable bit", 64'(d), 64'h0800_0000);
    endtask

    task automatic t_decode_enabled;
        dec_check("R9 rank0 start", 34'h0_0000_0000, 1);
        dec_check("R8 rank0 last byte", 34'h0_0FFF_FFFF, 1);
        dec_check("R7 rank1 base", 34'h0_1000_0000, 1);
        dec_check("R8 rank1 last byte", 34'h0_17FF_FFFF, 1);
        dec_check("R9 gap after rank1", 34'h0_1800_0000, 1);
        dec_check("R9 invalid rank2", 34'h1_0000_0000, 1);
        dec_check("R7 rank3 base above 4GiB", 34'h2_0000_0000, 1);
        dec_check("R8 rank3 4GiB size end", 34'h2_FFFF_FFFF, 1);
        dec_check("R8 rank3 limit", 34'h3_0000_0000, 1);
        dec_check("R9 rank3 offset", 34'h2_1234_5678, 1);
    endtask

    task automatic t_latency;
        @(negedge clk);
        mem_addr = 34'h3_0000_0000;
        @(negedge clk);
        mem_addr = 34'h0_0000_0040;
        chk("R10 before edge", 64'(dec_hit), 0);
        @(negedge clk);
        chk("R10 after edge hit", 64'(dec_hit), 1);
        chk("R10 after edge offset", 64'(dec_offset), 64'h40);
    endtask

    task automatic t_disable;
        logic [31:0] d;
        do_write(10'h010, 32'h21);
        do_write(10'h011, 32'hF7FF_FFFF);
        do_read(10'h011, d);
        chk("R5 options cleared", 64'(d), 0);
        dec_check("R10 disabled again", 34'h0_0000_0040, 0);
    endtask

    task automatic t_read_timing;
        logic [31:0] d;
        do_read(10'h055, d);
        chk("R11 unmapped port", 64'(d), 0);
        do_read(10'h040, d);
        @(negedge clk);
        reg_sel = 10'h010;
        @(negedge clk);
        chk("R11 rdata held without strobe", 64'(reg_rdata), 64'(masked(0)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_rank_readback;
        t_rank_write_ignored;
        t_index_port;
        t_fixed_reads;
        t_options_enable;
        t_decode_enabled;
        t_latency;
        t_disable;
        t_read_timing;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule